// File: doc/BRIEF.md
# Three-Channel Register Bank with Broadcast Write

This block holds three copies of the same register file, one per channel, all decoded from a single shared address space. One address bus and one write-data bus feed every copy. Which copies take a write is decided by four qualifiers that come from an address decoder upstream: one select line per channel and a broadcast line. A single transfer can therefore hit one channel, any mix of channels, or all of them in the same cycle.

Every register of every channel is driven out on a flat output vector, so the channel datapaths can use their settings directly. A combinational read port returns one word at the current address. The channel is picked by the same qualifiers, with a fixed priority. The register count, data width, address width and reset value are parameters.

Top module: `chan_bank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) loads every register of every channel with `RST_VAL` (default 32'hA5A5_0000). Reset takes priority over a write in the same cycle.
- R2: With `wr_en` high and `bcast_en` high at a rising edge, `wdata` is stored into the register at `addr` in all three channels.
- R3: With `wr_en` high, `bcast_en` low and exactly one bit `chan_en[k]` high, only channel k's register at `addr` is written. The other channels keep their values.
- R4: With `wr_en` high, `bcast_en` low and several `chan_en` bits high, every enabled channel is written and every other channel is unchanged.
- R5: A rising edge with `wr_en` low, or with `wr_en` high but `chan_en` = 3'b000 and `bcast_en` low, changes no register.
- R6: A write to an address of `NREG` (default 8) or above changes no register.
- R7: A write changes only the addressed register. Every other register in the written channels keeps its value.
- R8: `rd_data` is combinational. It is 0 when `addr` >= `NREG`. Otherwise it shows the register at `addr` of the lowest-numbered channel whose `chan_en` bit is high. If no `chan_en` bit is high, it shows channel 0 when `bcast_en` is high and 0 when `bcast_en` is low.
- R9: `chan_regs` holds register r of channel c at bits `[(c*NREG + r)*DW +: DW]`.
- R10: `bcast_en` writes all three channels no matter which `chan_en` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| chan_en | input | 3 | Per-channel select; bit k selects channel k |
| bcast_en | input | 1 | Broadcast select for all channels |
| addr | input | ADDR_W (4) | Shared register address for writes and reads |
| wdata | input | DW (32) | Shared write data |
| rd_data | output | DW (32) | Read-back word from the prioritised channel |
| chan_regs | output | 3*NREG*DW (768) | Flattened contents of all channel registers |

## Verification
Single-channel writes are easy to produce. The hard cases are the overlaps. One is a broadcast while some individual selects are also high, where the broadcast must win. Another is a subset of selects that must leave the unselected channel alone. A third is a strobe with a full set of qualifiers but an address past the last register. The stimulus table first gives each channel a different value at one shared address, so a write that lands in the wrong channel shows up as a mismatch. It then steps through these overlapping qualifier patterns and compares all 24 words after every edge. Read-only rows, placed after the channels have diverged, check the read priority.

// File: rtl/chan_bank_pkg.sv
package chan_bank_pkg;
    localparam int NUM_CH = 3;
    typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/cbank_wr_decode.sv
module cbank_wr_decode
    import chan_bank_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  ch_mask_t          chan_en,
    input  logic              bcast_en,
    input  logic [ADDR_W-1:0] addr,
    output ch_mask_t          ch_we
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREG);

    logic in_range;

    always_comb begin
        in_range = ({1'b0, addr} < LIMIT);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        always_comb begin
            ch_we[c] = wr_en & in_range & (bcast_en | chan_en[c]);
        end
    end
endmodule

// File: rtl/cbank_regfile.sv
module cbank_regfile #(
    parameter int              NREG    = 8,
    parameter int              DW      = 32,
    parameter int              ADDR_W  = 4,
    parameter logic [DW-1:0]   RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] regs_o,
    output logic [DW-1:0]      rd_word_o
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREG);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [IW-1:0] idx;
    logic          in_range;

    always_comb begin
        idx      = addr[IW-1:0];
        in_range = ({1'b0, addr} < LIMIT);
        st_d     = st_q;
        if (we && in_range) begin
            st_d.regs[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs <= {NREG{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        regs_o    = st_q.regs;
        rd_word_o = in_range ? st_q.regs[idx] : '0;
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> st_q.regs[$past(idx)] == $past(wdata));
endmodule

// File: rtl/cbank_rd_mux.sv
module cbank_rd_mux
    import chan_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  ch_mask_t                chan_en,
    input  logic                    bcast_en,
    input  logic [NUM_CH-1:0][DW-1:0] ch_words,
    output logic [DW-1:0]           rd_data
);
    ch_mask_t sel;

    always_comb begin
        sel = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (chan_en[c]) begin
                sel    = '0;
                sel[c] = 1'b1;
            end
        end
        if (chan_en == '0 && bcast_en) begin
            sel[0] = 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel[c]) begin
                rd_data = ch_words[c];
            end
        end
    end
endmodule

// File: rtl/chan_bank.sv
module chan_bank
    import chan_bank_pkg::*;
#(
    parameter int            NREG    = 8,
    parameter int            DW      = 32,
    parameter int            ADDR_W  = 4,
    parameter logic [DW-1:0] RST_VAL = 32'hA5A5_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                chan_en,
    input  logic                      bcast_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rd_data,
    output logic [3*NREG*DW-1:0]      chan_regs
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREG);

    ch_mask_t                  ch_we;
    logic [NUM_CH-1:0][DW-1:0] ch_words;
    logic                      in_range;
    logic [IW-1:0]             idx;

    always_comb begin
        in_range = ({1'b0, addr} < LIMIT);
        idx      = addr[IW-1:0];
    end

    cbank_wr_decode #(
        .NREG   (NREG),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .wr_en    (wr_en),
        .chan_en  (chan_en),
        .bcast_en (bcast_en),
        .addr     (addr),
        .ch_we    (ch_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cbank_regfile #(
            .NREG    (NREG),
            .DW      (DW),
            .ADDR_W  (ADDR_W),
            .RST_VAL (RST_VAL)
        ) u_rf (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (ch_we[c]),
            .addr      (addr),
            .wdata     (wdata),
            .regs_o    (chan_regs[c*NREG*DW +: NREG*DW]),
            .rd_word_o (ch_words[c])
        );
    end

    cbank_rd_mux #(
        .DW (DW)
    ) u_rd (
        .chan_en  (chan_en),
        .bcast_en (bcast_en),
        .ch_words (ch_words),
        .rd_data  (rd_data)
    );

    // R2
    bcast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bcast_en && in_range) |=>
            (chan_regs[(NREG + 32'($past(idx)))*DW +: DW] == $past(wdata)) &&
            (chan_regs[(2*NREG + 32'($past(idx)))*DW +: DW] == $past(wdata)) &&
            (chan_regs[32'($past(idx))*DW +: DW] == $past(wdata)));

    // R5
    no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == 3'b000 && !bcast_en) |=> $stable(chan_regs));

    // R6
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> $stable(chan_regs));

    // R8
    rd_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_en && chan_en == 3'b000) |-> rd_data == ch_words[0]);
endmodule

// File: tb/chan_bank_tb.sv
`timescale 1ns/1ps
module chan_bank_tb;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int AW   = 4;
    localparam logic [31:0] RSTV = 32'hA5A5_0000;

    typedef struct packed {
        logic        wr;
        logic [2:0]  ch;
        logic        bc;
        logic [3:0]  ad;
        logic [31:0] wd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'b000, 1'b1, 4'd2,  32'h1111_1111, 4'd2 },  // R2 broadcast
        '{1'b1, 3'b001, 1'b0, 4'd3,  32'h2222_2222, 4'd3 },  // R3 ch0
        '{1'b1, 3'b010, 1'b0, 4'd3,  32'h3333_3333, 4'd3 },  // R3 ch1
        '{1'b1, 3'b100, 1'b0, 4'd3,  32'h4444_4444, 4'd3 },  // R3 ch2
        '{1'b1, 3'b101, 1'b0, 4'd5,  32'h5555_5555, 4'd4 },  // R4 subset
        '{1'b1, 3'b010, 1'b1, 4'd6,  32'h6666_6666, 4'd10},  // R10 override
        '{1'b1, 3'b000, 1'b0, 4'd1,  32'h7777_7777, 4'd5 },  // R5 no select
        '{1'b0, 3'b111, 1'b1, 4'd1,  32'h8888_8888, 4'd5 },  // R5 strobe low
        '{1'b1, 3'b111, 1'b1, 4'd9,  32'h9999_9999, 4'd6 },  // R6 range
        '{1'b1, 3'b111, 1'b1, 4'd15, 32'h9999_0000, 4'd6 },  // R6 range top
        '{1'b0, 3'b110, 1'b0, 4'd3,  32'h0,         4'd8 },  // R8 ch1 first
        '{1'b0, 3'b000, 1'b1, 4'd3,  32'h0,         4'd8 },  // R8 bcast -> ch0
        '{1'b0, 3'b000, 1'b0, 4'd3,  32'h0,         4'd8 },  // R8 none -> 0
        '{1'b0, 3'b100, 1'b0, 4'd12, 32'h0,         4'd8 },  // R8 out of range
        '{1'b1, 3'b011, 1'b0, 4'd0,  32'hABCD_0123, 4'd7 },  // R7 R4
        '{1'b1, 3'b111, 1'b0, 4'd7,  32'hFEED_BEEF, 4'd4 }   // R4 all three
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [2:0]         chan_en;
    logic               bcast_en;
    logic [AW-1:0]      addr;
    logic [DW-1:0]      wdata;
    logic [DW-1:0]      rd_data;
    logic [3*NREG*DW-1:0] chan_regs;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] mdl [3][NREG];

    always #2 clk = ~clk;

    chan_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .chan_en   (chan_en),
        .bcast_en  (bcast_en),
        .addr      (addr),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .chan_regs (chan_regs)
    );

    function automatic logic [31:0] exp_rd(logic [2:0] ch, logic bc, logic [3:0] ad);
        if (ad >= NREG) return 32'h0;
        if (ch[0]) return mdl[0][ad[2:0]];
        if (ch[1]) return mdl[1][ad[2:0]];
        if (ch[2]) return mdl[2][ad[2:0]];
        if (bc)    return mdl[0][ad[2:0]];
        return 32'h0;
    endfunction

    task automatic check_all(input int rq);
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < NREG; r++) begin
                logic [31:0] got;
                got = chan_regs[(c*NREG + r)*DW +: DW];   // R9 layout
                n_chk++;
                if (got !== mdl[c][r]) begin
                    n_fail++;
                    $display("FAIL R%0d ch%0d reg%0d actual=%h expected=%h",
                             rq, c, r, got, mdl[c][r]);
                end
            end
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++)
            for (int r = 0; r < NREG; r++)
                mdl[c][r] = RSTV;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; chan_en = 3'b000; bcast_en = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all(1);                                   // R1 reset state

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] er;
            v = VECS[i];
            wr_en = v.wr; chan_en = v.ch; bcast_en = v.bc; addr = v.ad; wdata = v.wd;
            #1;
            er = exp_rd(v.ch, v.bc, v.ad);
            n_chk++;
            if (rd_data !== er) begin
                n_fail++;
                $display("FAIL R8 vec%0d rd_data actual=%h expected=%h", i, rd_data, er);
            end
            @(posedge clk);
            if (v.wr && v.ad < NREG) begin
                for (int c = 0; c < 3; c++)
                    if (v.bc || v.ch[c]) mdl[c][v.ad[2:0]] = v.wd;
            end
            @(negedge clk);
            check_all(int'(v.rq));
        end

        // R1: reset wins over a broadcast write in the same cycle
        wr_en = 1'b1; bcast_en = 1'b1; chan_en = 3'b111; addr = 4'd4;
        wdata = 32'h1234_5678; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0; bcast_en = 1'b0; chan_en = 3'b000;
        model_reset();
        check_all(1);

        // R7: write last register of ch2 only, neighbours untouched
        wr_en = 1'b1; chan_en = 3'b100; addr = 4'd7; wdata = 32'h0BAD_F00D;
        @(posedge clk);
        mdl[2][7] = 32'h0BAD_F00D;
        @(negedge clk);
        wr_en = 1'b0; chan_en = 3'b000;
        check_all(7);

        // R8: read back ch2 register 7 via ch2 select
        chan_en = 3'b100; addr = 4'd7; #1;
        n_chk++;
        if (rd_data !== 32'h0BAD_F00D) begin
            n_fail++;
            $display("FAIL R8 rd_data actual=%h expected=%h", rd_data, 32'h0BAD_F00D);
        end
        chan_en = 3'b000;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule